// File: doc/BRIEF.md
# Hybrid Hash and Associative Dictionary Map

This block stores key/value pairs for a dictionary-based compressor and answers one lookup per clock cycle. A 20-bit key passes through an XOR hash network that picks one bucket row. Each row holds a fixed number of slots, and all of them are read at once. The key is compared with every valid slot of that row. In the same cycle it is also compared with every entry of a small fully associative overflow store. The lookup port therefore gives its hit flag and 12-bit value combinationally from the registered contents.

An insert is written to the lowest free slot of the key's bucket. When that bucket is full, the insert goes to the next free entry of the overflow store. When both are full, the insert is dropped and a sticky flag records the loss. A synchronous clear empties the whole map at the start of each chunk. Entries are never deleted one at a time.

Top module: `hybrid_map`

## Requirements
- R1: The bucket index bit i is the XOR of the key bits selected by the 20-bit mask field i of parameter HASH_MASK. With the default of 6 index bits, mask i selects the key bits j for which j mod 6 equals i, so keys 0x00041, 0x01040, 0x41000, 0x00082, 0x01001, 0x02080 and 0x04100 all share bucket 0, and key 0x00001 falls in bucket 1.
- R2: A lookup is combinational from lk_key. lk_hit is 1 and lk_val gives the stored value when a valid entry holds exactly that key. Otherwise lk_hit is 0 and lk_val is 0.
- R3: Each bucket has 2 slots. An accepted insert fills the lowest-numbered free slot of its bucket. The entry is visible to lookups from the cycle after the insert edge.
- R4: An insert whose bucket has no free slot is written to the associative store, which matches on the full 20-bit key. The default store depth is 4.
- R5: ovf_full is 1 when every associative entry is in use. An insert that finds both its bucket and the store full is discarded and sets ovf_drop, which stays at 1 until the next clear or reset.
- R6: When several entries match a key, a bucket slot wins over the associative store, and a lower slot wins over a higher slot.
- R7: When clr is high at a clock edge, every slot and associative entry is invalidated and ovf_full and ovf_drop return to 0. An insert presented in the same cycle is ignored.
- R8: After reset the map is empty: every lookup misses, and ovf_full and ovf_drop are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear of all entries and flags |
| ins_valid | input | 1 | Insert request this cycle |
| ins_key | input | 20 | Key to insert |
| ins_val | input | 12 | Value to insert |
| lk_key | input | 20 | Key to look up |
| lk_hit | output | 1 | Lookup found the key |
| lk_val | output | 12 | Value found, 0 on a miss |
| ovf_full | output | 1 | Associative store has no free entry |
| ovf_drop | output | 1 | Sticky: at least one insert was discarded |

## Verification
A bad hash bit or a wrong slot choice sends a key to a row where the lookup does not search. It then shows as a miss, or as a hit with a stale value, in the cycle after the insert. The same fault also fills the overflow store too early or too late, so ovf_full and ovf_drop change state on a different insert from the one the collision pattern predicts. A priority fault shows only when a key is stored twice, and then appears on the very next lookup of that key. A clear that leaves any valid bit set shows at once as a hit that should be a miss.

// File: rtl/hm_pkg.sv
package hm_pkg;
  localparam int KEY_W_DEF = 20;
  localparam int VAL_W_DEF = 12;
  typedef enum logic [1:0] {
    DST_NONE   = 2'd0,
    DST_BUCKET = 2'd1,
    DST_ASSOC  = 2'd2,
    DST_DROP   = 2'd3
  } ins_dst_e;
endpackage

// File: rtl/hm_hash.sv
module hm_hash #(
  parameter int KEY_W = 20,
  parameter int IDX_W = 6,
  parameter logic [IDX_W*KEY_W-1:0] HASH_MASK = '0
) (
  input  logic [KEY_W-1:0] key,
  output logic [IDX_W-1:0] idx
);
  for (genvar i = 0; i < IDX_W; i++) begin : g_bit
    assign idx[i] = ^(key & HASH_MASK[i*KEY_W +: KEY_W]);
  end
endmodule

// File: rtl/hm_bucket_store.sv
module hm_bucket_store #(
  parameter int KEY_W = 20,
  parameter int VAL_W = 12,
  parameter int IDX_W = 6,
  parameter int SLOTS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [KEY_W-1:0] wr_key,
  input  logic [VAL_W-1:0] wr_val,
  output logic             wr_room,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [KEY_W-1:0] rd_key,
  output logic             rd_hit,
  output logic [VAL_W-1:0] rd_val
);
  localparam int NB = 1 << IDX_W;
  localparam int SL_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  logic [SLOTS-1:0] vld [NB];
  logic [KEY_W-1:0] keys [NB][SLOTS];
  logic [VAL_W-1:0] vals [NB][SLOTS];
  logic [SL_W-1:0]  free_sel;
  logic [SLOTS-1:0] row_vld;

  assign row_vld = vld[wr_idx];
  assign wr_room = ~&row_vld;

  always_comb begin
    free_sel = '0;
    for (int s = SLOTS - 1; s >= 0; s--) begin
      if (!row_vld[s]) free_sel = SL_W'(s);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NB; b++) vld[b] <= '0;
    end else if (clr) begin
      for (int b = 0; b < NB; b++) vld[b] <= '0;
    end else if (wr_en && wr_room) begin
      vld[wr_idx][free_sel] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && wr_room && !clr) begin
      keys[wr_idx][free_sel] <= wr_key;
      vals[wr_idx][free_sel] <= wr_val;
    end
  end

  always_comb begin
    rd_hit = 1'b0;
    rd_val = '0;
    for (int s = SLOTS - 1; s >= 0; s--) begin
      if (vld[rd_idx][s] && keys[rd_idx][s] == rd_key) begin
        rd_hit = 1'b1;
        rd_val = vals[rd_idx][s];
      end
    end
  end
endmodule

// File: rtl/hm_assoc_store.sv
module hm_assoc_store #(
  parameter int KEY_W = 20,
  parameter int VAL_W = 12,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr_en,
  input  logic [KEY_W-1:0] wr_key,
  input  logic [VAL_W-1:0] wr_val,
  output logic             full,
  input  logic [KEY_W-1:0] rd_key,
  output logic             rd_hit,
  output logic [VAL_W-1:0] rd_val
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0] used;
  logic [KEY_W-1:0] ekey [DEPTH];
  logic [VAL_W-1:0] eval [DEPTH];
  logic [DEPTH-1:0] match;

  assign full = (used == CNT_W'(DEPTH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                used <= '0;
    else if (clr)              used <= '0;
    else if (wr_en && !full)   used <= used + 1'b1;
  end

  always_ff @(posedge clk) begin
    for (int e = 0; e < DEPTH; e++) begin
      if (wr_en && !full && !clr && used == CNT_W'(e)) begin
        ekey[e] <= wr_key;
        eval[e] <= wr_val;
      end
    end
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_cmp
    assign match[e] = (used > CNT_W'(e)) && (ekey[e] == rd_key);
  end

  always_comb begin
    rd_hit = |match;
    rd_val = '0;
    for (int e = DEPTH - 1; e >= 0; e--) begin
      if (match[e]) rd_val = eval[e];
    end
  end
endmodule

// File: rtl/hybrid_map.sv
module hybrid_map
  import hm_pkg::*;
#(
  parameter int KEY_W = KEY_W_DEF,
  parameter int VAL_W = VAL_W_DEF,
  parameter int IDX_W = 6,
  parameter int SLOTS = 2,
  parameter int ASSOC_DEPTH = 4,
  parameter logic [IDX_W*KEY_W-1:0] HASH_MASK =
    120'h20820_10410_08208_04104_82082_41041
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             ins_valid,
  input  logic [KEY_W-1:0] ins_key,
  input  logic [VAL_W-1:0] ins_val,
  input  logic [KEY_W-1:0] lk_key,
  output logic             lk_hit,
  output logic [VAL_W-1:0] lk_val,
  output logic             ovf_full,
  output logic             ovf_drop
);
  logic [IDX_W-1:0] ins_idx, lk_idx;
  logic             bkt_room, bkt_hit, cam_hit;
  logic [VAL_W-1:0] bkt_val, cam_val;
  ins_dst_e         dst;
  logic             ins_to_bkt, ins_to_cam, ins_drop;

  hm_hash #(.KEY_W(KEY_W), .IDX_W(IDX_W), .HASH_MASK(HASH_MASK)) u_hash_ins (
    .key(ins_key), .idx(ins_idx));
  hm_hash #(.KEY_W(KEY_W), .IDX_W(IDX_W), .HASH_MASK(HASH_MASK)) u_hash_lk (
    .key(lk_key), .idx(lk_idx));

  always_comb begin
    dst = DST_NONE;
    if (ins_valid && !clr) begin
      if (bkt_room)       dst = DST_BUCKET;
      else if (!ovf_full) dst = DST_ASSOC;
      else                dst = DST_DROP;
    end
  end

  assign ins_to_bkt = (dst == DST_BUCKET);
  assign ins_to_cam = (dst == DST_ASSOC);
  assign ins_drop   = (dst == DST_DROP);

  hm_bucket_store #(.KEY_W(KEY_W), .VAL_W(VAL_W), .IDX_W(IDX_W), .SLOTS(SLOTS)) u_bkt (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .wr_en(ins_to_bkt), .wr_idx(ins_idx), .wr_key(ins_key), .wr_val(ins_val),
    .wr_room(bkt_room),
    .rd_idx(lk_idx), .rd_key(lk_key), .rd_hit(bkt_hit), .rd_val(bkt_val));

  hm_assoc_store #(.KEY_W(KEY_W), .VAL_W(VAL_W), .DEPTH(ASSOC_DEPTH)) u_cam (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .wr_en(ins_to_cam), .wr_key(ins_key), .wr_val(ins_val), .full(ovf_full),
    .rd_key(lk_key), .rd_hit(cam_hit), .rd_val(cam_val));

  assign lk_hit = bkt_hit | cam_hit;
  assign lk_val = bkt_hit ? bkt_val : (cam_hit ? cam_val : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ovf_drop <= 1'b0;
    else if (clr)      ovf_drop <= 1'b0;
    else if (ins_drop) ovf_drop <= 1'b1;
  end
endmodule

// File: rtl/hybrid_map_chk.sv
module hybrid_map_chk #(
  parameter int KEY_W = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr,
  input logic [KEY_W-1:0] ins_key,
  input logic [KEY_W-1:0] lk_key,
  input logic             lk_hit,
  input logic             ovf_full,
  input logic             ovf_drop,
  input logic             ins_to_bkt,
  input logic             ins_to_cam,
  input logic             ins_drop,
  input logic             bkt_room
);
  a_r5_one_dest: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ins_to_bkt, ins_to_cam, ins_drop}));
  a_r3_bucket_visible: assert property (@(posedge clk) disable iff (!rst_n)
    ins_to_bkt |=> (lk_key != $past(ins_key)) || lk_hit);
  a_r4_assoc_visible: assert property (@(posedge clk) disable iff (!rst_n)
    ins_to_cam |=> (lk_key != $past(ins_key)) || lk_hit);
  a_r4_assoc_only_when_bucket_full: assert property (@(posedge clk) disable iff (!rst_n)
    ins_to_cam |-> !bkt_room);
  a_r5_drop_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
    ins_drop |-> (ovf_full && !bkt_room));
  a_r5_drop_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_drop && !clr) |=> ovf_drop);
  a_r5_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_full && !clr) |=> ovf_full);
  a_r7_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!ovf_full && !ovf_drop && !lk_hit));
endmodule

bind hybrid_map hybrid_map_chk #(.KEY_W(KEY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .ins_key(ins_key), .lk_key(lk_key),
  .lk_hit(lk_hit), .ovf_full(ovf_full), .ovf_drop(ovf_drop),
  .ins_to_bkt(ins_to_bkt), .ins_to_cam(ins_to_cam), .ins_drop(ins_drop),
  .bkt_room(bkt_room));

// File: tb/hybrid_map_bench.sv
module hybrid_map_bench;
  localparam int CLK_P = 10;
  localparam int NV = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr = 1'b0;
  logic        ins_valid = 1'b0;
  logic [19:0] ins_key = '0;
  logic [11:0] ins_val = '0;
  logic [19:0] lk_key = '0;
  logic        lk_hit;
  logic [11:0] lk_val;
  logic        ovf_full, ovf_drop;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  hybrid_map u_hybrid_map (
    .clk(clk), .rst_n(rst_n), .clr(clr), .ins_valid(ins_valid),
    .ins_key(ins_key), .ins_val(ins_val), .lk_key(lk_key),
    .lk_hit(lk_hit), .lk_val(lk_val), .ovf_full(ovf_full), .ovf_drop(ovf_drop));

  // {is_insert, key, value, expected hit}; a lookup expects value when hit, 0 otherwise.
  // Keys with bit-class XOR 0 share bucket 0 (R1); 0x00001 lands in bucket 1.
  localparam logic [33:0] TBL [0:NV-1] = '{
    {1'b0, 20'h00041, 12'h000, 1'b0},  // R8 empty
    {1'b1, 20'h00041, 12'h111, 1'b0},  // R3 slot 0
    {1'b0, 20'h00041, 12'h111, 1'b1},  // R2
    {1'b1, 20'h01040, 12'h222, 1'b0},  // R3 slot 1
    {1'b0, 20'h01040, 12'h222, 1'b1},  // R3
    {1'b0, 20'h00041, 12'h111, 1'b1},  // R3
    {1'b1, 20'h41000, 12'h333, 1'b0},  // R4 to assoc
    {1'b0, 20'h41000, 12'h333, 1'b1},  // R4
    {1'b1, 20'h00082, 12'h444, 1'b0},  // R4
    {1'b1, 20'h01001, 12'h555, 1'b0},  // R4
    {1'b1, 20'h02080, 12'h666, 1'b0},  // R4 store now full
    {1'b0, 20'h02080, 12'h666, 1'b1},  // R4
    {1'b0, 20'h00082, 12'h444, 1'b1},  // R4
    {1'b1, 20'h04100, 12'h777, 1'b0},  // R5 dropped
    {1'b0, 20'h04100, 12'h000, 1'b0},  // R5 miss
    {1'b1, 20'h00001, 12'h0AB, 1'b0},  // R1 other bucket has room
    {1'b0, 20'h00001, 12'h0AB, 1'b1},  // R1
    {1'b0, 20'h01001, 12'h555, 1'b1},  // R4
    {1'b0, 20'h00002, 12'h000, 1'b0},  // R2 never stored
    {1'b0, 20'h41000, 12'h333, 1'b1}   // R4
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_ins(input logic [19:0] k, input logic [11:0] v, input logic with_clr);
    @(negedge clk);
    ins_valid = 1'b1; ins_key = k; ins_val = v; clr = with_clr;
    @(negedge clk);
    ins_valid = 1'b0; clr = 1'b0;
  endtask

  task automatic do_lk(input string req, input logic [19:0] k, input logic h, input logic [11:0] v);
    @(negedge clk);
    lk_key = k;
    #1;
    check(req, {31'd0, lk_hit}, {31'd0, h});
    check(req, {20'd0, lk_val}, {20'd0, (h ? v : 12'h000)});
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R8 ovf_full", {31'd0, ovf_full}, 32'd0);
    check("R8 ovf_drop", {31'd0, ovf_drop}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      if (TBL[i][33]) do_ins(TBL[i][32:13], TBL[i][12:1], 1'b0);
      else do_lk($sformatf("R2 vec %0d", i), TBL[i][32:13], TBL[i][0], TBL[i][12:1]);
      if (i == 11) begin
        check("R5 full after fourth spill", {31'd0, ovf_full}, 32'd1);
        check("R5 no drop yet", {31'd0, ovf_drop}, 32'd0);
      end
    end
    check("R5 drop sticky", {31'd0, ovf_drop}, 32'd1);
    check("R5 still full", {31'd0, ovf_full}, 32'd1);

    // R7: clear empties the map and its flags
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    #1;
    check("R7 full cleared", {31'd0, ovf_full}, 32'd0);
    check("R7 drop cleared", {31'd0, ovf_drop}, 32'd0);
    do_lk("R7 bucket entry gone", 20'h00041, 1'b0, 12'h000);
    do_lk("R7 assoc entry gone", 20'h41000, 1'b0, 12'h000);

    // R7: insert coinciding with clear is ignored
    do_ins(20'h00001, 12'h0CD, 1'b1);
    do_lk("R7 insert during clear", 20'h00001, 1'b0, 12'h000);

    // R6: priorities among duplicates
    do_ins(20'h00041, 12'h100, 1'b0);
    do_ins(20'h00041, 12'h200, 1'b0);
    do_lk("R6 lower slot wins", 20'h00041, 1'b1, 12'h100);
    do_ins(20'h00041, 12'h300, 1'b0);
    do_lk("R6 bucket over assoc", 20'h00041, 1'b1, 12'h100);
    check("R4 spill not full", {31'd0, ovf_full}, 32'd0);

    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected done");
      finish_run();
    end
  end
endmodule